// File: doc/BRIEF.md
# Set-Clear-Toggle Register Bank

This block holds a configurable number of 32-bit control registers behind a simple single-cycle memory-mapped request/response bus. Each register sits in its own 16-byte address slot. The slot has four word-aligned aliases, and the low address nibble of a write selects what the write does. A write at nibble 0x0 replaces the whole word. A write at 0x4 ORs the data in, a write at 0x8 removes the data bits, and a write at 0xC inverts the data bits. Software can therefore change individual control bits without a read-modify-write sequence of its own.

A read at any of the four aliases returns the stored value. The bank accepts only aligned full-word accesses. A misaligned or narrow access, or one whose slot lies past the last register, changes nothing and gets an error response. Every request gets exactly one registered response on the following clock edge. The bank clears to zero under a synchronous active-high reset.

Top module: `scb_bank`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `rsp_valid` is 0. Every register reads as zero after reset.
- R2: A write at a slot's nibble 0x0 stores `req_wdata` as the new register value.
- R3: A write at nibble 0x4 sets each register bit whose `req_wdata` bit is 1 and leaves the other bits unchanged (OR).
- R4: A write at nibble 0x8 clears each register bit whose `req_wdata` bit is 1 and leaves the other bits unchanged (AND with inverted data).
- R5: A write at nibble 0xC inverts each register bit whose `req_wdata` bit is 1 (XOR).
- R6: A read at any of the nibbles 0x0, 0x4, 0x8 or 0xC returns the stored value and changes no register.
- R7: The register index is `req_addr` shifted right by four. A write changes only the register at that index.
- R8: A request accepted at a clock edge produces `rsp_valid`=1 on that same edge, and no response appears without a request. A write's effect is visible to a read issued in the next cycle.
- R9: A request with `req_addr[1:0]` not 0, or with `req_size` not 2'b10 (word), changes no register and responds with `rsp_err`=1 and `rsp_rdata`=0.
- R10: A request whose index is NUM_REGS or more responds with `rsp_err`=1 and `rsp_rdata`=0, and a write there changes no register.
- R11: A well-formed, in-range request responds with `rsp_err`=0. A write's response carries `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset; bits above 3 are the index, bits 3:2 pick the alias |
| req_size | input | 2 | Access size; 2'b10 = 32-bit word, anything else is rejected |
| req_wdata | input | DATA_W | Write data / bit mask |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | DATA_W | Read data; zero for writes and errors |

## Verification
A request driven before a rising edge has its response on `rsp_valid`, `rsp_err` and `rsp_rdata` one edge later. A write's register change lands on that same edge, so a read driven in the very next cycle must already see it. The bench drives one request at each falling edge. At the next falling edge it compares the registered response against the expectation its reference model formed when the request was driven, and only then drives the following request. Back-to-back write-then-read pairs on one slot check the same-edge visibility, and error cases are followed by reads that confirm nothing moved.

// File: rtl/scb_pkg.sv
package scb_pkg;
  // Operation chosen by address bits [3:2]
  typedef enum logic [1:0] {
    OP_WRITE  = 2'b00,
    OP_SET    = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_TOGGLE = 2'b11
  } scb_op_e;

  localparam logic [1:0] SIZE_WORD = 2'b10;
endpackage

// File: rtl/scb_decode.sv
module scb_decode
  import scb_pkg::*;
#(
  parameter int NUM_REGS = 12,
  parameter int ADDR_W   = $clog2(NUM_REGS) + 4,
  parameter int IDX_W    = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [IDX_W-1:0]  idx,
  output scb_op_e           op,
  output logic              ok
);
  logic shape_ok;
  logic in_range;

  always_comb begin
    idx      = addr[ADDR_W-1:4];
    op       = scb_op_e'(addr[3:2]);
    shape_ok = (addr[1:0] == 2'b00) && (size == SIZE_WORD);
    in_range = (int'(idx) < NUM_REGS);
    ok       = shape_ok && in_range;
  end
endmodule

// File: rtl/scb_update.sv
module scb_update
  import scb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  input  scb_op_e           op,
  output logic [DATA_W-1:0] nxt
);
  always_comb begin
    unique case (op)
      OP_WRITE:  nxt = wdata;
      OP_SET:    nxt = cur | wdata;
      OP_CLEAR:  nxt = cur & ~wdata;
      OP_TOGGLE: nxt = cur ^ wdata;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/scb_slot.sv
module scb_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= din;
  end
endmodule

// File: rtl/scb_bank.sv
module scb_bank
  import scb_pkg::*;
#(
  parameter int NUM_REGS = 12,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int ADDR_W  = IDX_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [IDX_W-1:0]         idx;
  scb_op_e                  op;
  logic                     ok;
  logic [DATA_W-1:0]        cur;
  logic [DATA_W-1:0]        nxt;
  logic [DATA_W-1:0]        regs_q [NUM_REGS];
  logic [NUM_REGS*DATA_W-1:0] regs_flat;
  logic                     wr_ok;

  scb_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr (req_addr),
    .size (req_size),
    .idx  (idx),
    .op   (op),
    .ok   (ok)
  );

  // Read mux: and-or selection so an out-of-range index yields zero
  always_comb begin
    cur = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) cur = regs_q[i];
    end
  end

  scb_update #(.DATA_W(DATA_W)) u_upd (
    .cur   (cur),
    .wdata (req_wdata),
    .op    (op),
    .nxt   (nxt)
  );

  assign wr_ok = req_valid && req_write && ok;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    scb_slot #(.DATA_W(DATA_W)) u_slot (
      .clk (clk),
      .rst (rst),
      .we  (wr_ok && (idx == IDX_W'(g))),
      .din (nxt),
      .q   (regs_q[g])
    );
    assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !ok;
      rsp_rdata <= (req_valid && !req_write && ok) ? cur : '0;
    end
  end
endmodule

// File: rtl/scb_bank_chk.sv
module scb_bank_chk #(
  parameter int NUM_REGS = 12,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       req_valid,
  input logic                       req_write,
  input logic [ADDR_W-1:0]          req_addr,
  input logic [1:0]                 req_size,
  input logic                       rsp_valid,
  input logic                       rsp_err,
  input logic [DATA_W-1:0]          rsp_rdata,
  input logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  logic bad_shape;
  logic out_range;

  assign bad_shape = (req_addr[1:0] != 2'b00) || (req_size != 2'b10);
  assign out_range = (int'(req_addr[ADDR_W-1:4]) >= NUM_REGS);

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!rsp_valid && regs_flat == '0));

  p_resp_follows_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_read_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> $stable(regs_flat));

  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

  p_bad_shape_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bad_shape) |=> (rsp_err && $stable(regs_flat)));

  p_out_range_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && out_range) |=> (rsp_err && $stable(regs_flat)));

  p_clean_ok_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !bad_shape && !out_range) |=> !rsp_err);
endmodule

bind scb_bank scb_bank_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .regs_flat (regs_flat)
);

// File: tb/scb_bank_tb.sv
module scb_bank_tb;
  localparam int NREG = 12;
  localparam int AW   = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]  req_size = 2'b10;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model state and pending expectation
  logic [31:0] mdl [NREG];
  logic        exp_valid = 1'b0;
  logic        exp_err   = 1'b0;
  logic [31:0] exp_rdata = '0;
  string       exp_tag   = "R1";

  always #4 clk = ~clk;

  scb_bank #(.NUM_REGS(NREG), .DATA_W(32)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  task automatic compare();
    checks++;
    if (rsp_valid !== exp_valid) begin
      fails++;
      $display("FAIL %s rsp_valid actual=%b expected=%b", exp_tag, rsp_valid, exp_valid);
    end
    if (exp_valid) begin
      checks++;
      if (rsp_err !== exp_err) begin
        fails++;
        $display("FAIL %s rsp_err actual=%b expected=%b", exp_tag, rsp_err, exp_err);
      end
      checks++;
      if (rsp_rdata !== exp_rdata) begin
        fails++;
        $display("FAIL %s rsp_rdata actual=%h expected=%h", exp_tag, rsp_rdata, exp_rdata);
      end
    end
  endtask

  // One clock: check last response, predict this request, drive it
  task automatic step(input logic v, input logic w, input logic [AW-1:0] a,
                      input logic [1:0] sz, input logic [31:0] d, input string tag);
    int  ix;
    bit  bad;
    @(negedge clk);
    compare();
    ix  = int'(a[AW-1:4]);
    bad = (a[1:0] != 2'b00) || (sz != 2'b10) || (ix >= NREG);
    exp_valid = v;
    exp_err   = v && bad;
    exp_rdata = '0;
    exp_tag   = tag;
    if (v && !bad) begin
      if (!w) exp_rdata = mdl[ix];
      else begin
        case (a[3:2])
          2'b00: mdl[ix] = d;
          2'b01: mdl[ix] = mdl[ix] | d;
          2'b10: mdl[ix] = mdl[ix] & ~d;
          default: mdl[ix] = mdl[ix] ^ d;
        endcase
      end
    end
    req_valid = v; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1'b1, 1'b0, a, 2'b10, 32'h0, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b1, a, 2'b10, d, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: no response right after reset, all slots read zero
    step(1'b0, 1'b0, '0, 2'b10, '0, "R1");
    for (int i = 0; i < NREG; i++) rd(AW'(i * 16), "R1");

    // R2: plain write, then read every alias (R6)
    wr(8'h30, 32'hA5A5_0F0F, "R2");
    rd(8'h30, "R6");
    rd(8'h34, "R6");
    rd(8'h38, "R6");
    rd(8'h3C, "R6");
    // R3 set, R4 clear, R5 toggle, each read back next cycle (R8)
    wr(8'h34, 32'h0000_F0F0, "R3");
    rd(8'h30, "R3");
    wr(8'h38, 32'hA000_000F, "R4");
    rd(8'h30, "R4");
    wr(8'h3C, 32'hFFFF_0000, "R5");
    rd(8'h30, "R5");
    wr(8'h3C, 32'hFFFF_0000, "R5");
    rd(8'h38, "R5");
    // R7: neighbouring slots untouched
    wr(8'h40, 32'h1234_5678, "R7");
    rd(8'h30, "R7");
    rd(8'h50, "R7");
    rd(8'h40, "R7");
    // R8: idle gap then back-to-back
    step(1'b0, 1'b0, '0, 2'b10, '0, "R8");
    wr(8'hB0, 32'hDEAD_BEEF, "R8");
    rd(8'hB4, "R8");
    // R9: misaligned and narrow accesses
    wr(8'h32, 32'hFFFF_FFFF, "R9");
    wr(8'h41, 32'hFFFF_FFFF, "R9");
    step(1'b1, 1'b1, 8'h40, 2'b00, 32'h0, "R9");
    step(1'b1, 1'b0, 8'h30, 2'b01, 32'h0, "R9");
    rd(8'h30, "R9");
    rd(8'h40, "R9");
    // R10: slots 12..15 do not exist
    wr(8'hC0, 32'hFFFF_FFFF, "R10");
    rd(8'hC0, "R10");
    wr(8'hFC, 32'h0000_0001, "R10");
    rd(8'hF8, "R10");
    for (int i = 0; i < NREG; i++) rd(AW'(i * 16 + 4), "R10");

    // R11 and broad mixing: pseudo-random traffic
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      logic [1:0]    sz;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a  = lfsr[7:0];
      if (lfsr[13] || lfsr[14]) a[1:0] = 2'b00;
      sz = (lfsr[12:10] == 3'b000) ? lfsr[9:8] : 2'b10;
      step(lfsr[15] | lfsr[2], lfsr[11], a, sz,
           {lfsr, lfsr[7:0], lfsr[15:8]}, "R11");
    end
    for (int i = 0; i < NREG; i++) rd(AW'(i * 16 + 8), "R7");
    step(1'b0, 1'b0, '0, 2'b10, '0, "R8");
    step(1'b0, 1'b0, '0, 2'b10, '0, "R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule